// File: doc/BRIEF.md
# Scan Test Sequencer

This block drives a circuit whose state flops are built as mux-D scan cells. The sequencer owns two control pins of that circuit, the mode select and the serial input, and it owns the circuit's primary inputs. It watches the serial output and the primary outputs. On a start pulse it first proves that the chain can carry data. It sends a short transition pattern through every stage and checks that the pattern comes out intact after exactly one chain length. Only after that check does it apply test vectors.

Each vector sets the present state of the chain through serial loading. The vector then supplies a primary-input word and holds functional mode for a single clock. On that clock the primary outputs are checked and the next state is captured. The captured state leaves the chain while the following vector's present state enters it on the same shift clocks. Vectors and their expected responses live in a small internal table that is written through a simple write port. The run stops at the first mismatch and reports which vector failed. A broken chain is reported on its own flag.

Top module: `scan_test_seq`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `chain_fail` and `test_mode` are all 0.
- R2: With `test_mode` at 1, the chain takes `scan_in` into stage 0 and presents its last stage on `scan_out`. The sequencer sends a state word most significant bit first and reassembles the word it receives in the same order. As a result, stage i holds bit i after loading.
- R3: A run opens with 2×CHAIN_LEN shift clocks. The bit sent on clock k (k < CHAIN_LEN) is bit 1 of k, which gives 0,0,1,1 repeated, and the remaining clocks send 0. The value of `scan_out` on clock CHAIN_LEN+k must equal the bit sent on clock k. On any mismatch the run ends at once with `chain_fail`=1 and `pass`=0, and no capture clock is issued.
- R4: Each vector's present state is loaded with exactly CHAIN_LEN consecutive clocks at `test_mode`=1.
- R5: Each vector gets exactly one clock with `test_mode`=0, during which `pi` carries that vector's input word. The primary outputs sampled on that clock must equal the vector's expected output word.
- R6: The response of vector v leaves the chain on the same CHAIN_LEN clocks that load vector v+1. The last response leaves on CHAIN_LEN clocks that shift in zeros. Each unloaded word must equal the vector's expected next state.
- R7: The run stops at the first failing check, in time order. At that point `done`=1, `pass`=0, `chain_fail`=0 and `fail_idx` holds the failing vector's index. No capture clock follows the failure.
- R8: A run with V ≥ 1 vectors and no mismatch ends with `done`=1 and `pass`=1. It spends 2×CHAIN_LEN+(V+1)×CHAIN_LEN clocks at `test_mode`=1 and V clocks at `test_mode`=0 while `busy`=1.
- R9: A run with zero vectors consists of the chain check alone: 2×CHAIN_LEN shift clocks, then `pass`=1.
- R10: Each table entry is laid out, from MSB to LSB, as {present state, input word, expected output word, expected next state}. Entry i holds vector i. `num_vec` is sampled on the start clock and capped at MAX_VEC.
- R11: A `start` pulse while `busy`=1 has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the scanned circuit |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when not busy |
| num_vec | input | VCW | Vector count for the run |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | VAW | Table write index |
| tbl_wdata | input | EW | Table entry {state, input, output, next state} |
| test_mode | output | 1 | 1 = shift, 0 = functional clock |
| scan_in | output | 1 | Serial data into chain stage 0 |
| pi | output | PI_W | Primary inputs of the scanned circuit |
| scan_out | input | 1 | Serial data from the last chain stage |
| po | input | PO_W | Primary outputs of the scanned circuit |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| pass | output | 1 | Run finished with no mismatch |
| chain_fail | output | 1 | Chain integrity check failed |
| fail_idx | output | VAW | Index of the first failing vector |

## Verification
The unload of vector v's captured state and the load of vector v+1's present state share the same shift clocks. A fault in that shared window could be attributed to the wrong vector. The bench corrupts the expected next state of an interior vector while keeping its neighbours correct. It then requires `fail_idx` to name that interior vector, not the one being loaded, and it requires the number of capture clocks to match the failure point. A second case corrupts both the next state of one vector and the output word of the following vector, so that the earlier check must win. A third case corrupts the final vector, whose response leaves only through the zero-padded unload.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_SHIFT,
    ST_CAPT,
    ST_DONE
  } seq_state_t;

  // Transition pattern bit for shift position k: 0,0,1,1 repeating.
  function automatic logic flush_bit(input logic [1:0] k);
    return k[1];
  endfunction

endpackage

// File: rtl/scan_vec_store.sv
module scan_vec_store #(
  parameter int WIDTH = 27,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/scan_flush_ref.sv
module scan_flush_ref
  import scan_seq_pkg::*;
#(
  parameter int N  = 8,
  parameter int CW = 5
) (
  input  logic [CW-1:0] cnt,
  output logic [N-1:0]  pat,
  output logic          check_en,
  output logic          exp_bit
);

  logic [CW-1:0] lag;

  // Word preloaded into the shifter: its MSB goes out first.
  for (genvar i = 0; i < N; i++) begin : g_pat
    assign pat[N-1-i] = flush_bit(2'(i));
  end

  assign check_en = (cnt >= CW'(N));
  assign lag      = cnt - CW'(N);
  assign exp_bit  = check_en & flush_bit(lag[1:0]);

endmodule

// File: rtl/scan_shift_unit.sv
module scan_shift_unit #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [N-1:0] load_val,
  input  logic         shift,
  input  logic         ser_in,
  output logic         drive_bit,
  output logic [N-1:0] cap_next
);

  logic [N-1:0] sh_q;
  logic [N-1:0] cap_q;

  assign drive_bit = sh_q[N-1];
  assign cap_next  = {cap_q[N-2:0], ser_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cap_q <= '0;
    end else begin
      if (load)       sh_q <= load_val;
      else if (shift) sh_q <= {sh_q[N-2:0], 1'b0};
      if (shift)      cap_q <= cap_next;
    end
  end

endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int PI_W      = 4,
  parameter int PO_W      = 3,
  parameter int MAX_VEC   = 16,
  localparam int VAW = $clog2(MAX_VEC),
  localparam int VCW = $clog2(MAX_VEC + 1),
  localparam int EW  = 2 * CHAIN_LEN + PI_W + PO_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [VCW-1:0]  num_vec,
  input  logic            tbl_we,
  input  logic [VAW-1:0]  tbl_addr,
  input  logic [EW-1:0]   tbl_wdata,
  output logic            test_mode,
  output logic            scan_in,
  output logic [PI_W-1:0] pi,
  input  logic            scan_out,
  input  logic [PO_W-1:0] po,
  output logic            busy,
  output logic            done,
  output logic            pass,
  output logic            chain_fail,
  output logic [VAW-1:0]  fail_idx
);

  localparam int N  = CHAIN_LEN;
  localparam int CW = $clog2(2 * N) + 1;
  localparam int NS_LO = 0;
  localparam int PO_LO = N;
  localparam int PI_LO = N + PO_W;
  localparam int PS_LO = N + PO_W + PI_W;

  seq_state_t state_q;
  logic [CW-1:0]   cnt_q;
  logic [VCW-1:0]  vidx_q, nvec_q, nxt_vidx, nvec_in;
  logic [VAW-1:0]  rd_addr_q;
  logic [EW-1:0]   rd_data;
  logic            have_prev_q;
  logic [PI_W-1:0] cur_pi_q, pi_q;
  logic [PO_W-1:0] cur_po_q;
  logic [N-1:0]    cur_ns_q, prev_ns_q;
  logic            tm_q, busy_q, done_q, pass_q, cfail_q;
  logic [VAW-1:0]  fidx_q;

  logic            su_load, su_shift;
  logic [N-1:0]    su_val, pat, cap_next;
  logic            chk_en, exp_bit;
  logic            start_ok, flush_end, flush_err, last_shift, ns_err, po_err, more;

  scan_vec_store #(.WIDTH(EW), .DEPTH(MAX_VEC)) u_store (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_wdata),
    .raddr (rd_addr_q),
    .rdata (rd_data)
  );

  scan_flush_ref #(.N(N), .CW(CW)) u_flush (
    .cnt      (cnt_q),
    .pat      (pat),
    .check_en (chk_en),
    .exp_bit  (exp_bit)
  );

  scan_shift_unit #(.N(N)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (su_load),
    .load_val  (su_val),
    .shift     (su_shift),
    .ser_in    (scan_out),
    .drive_bit (scan_in),
    .cap_next  (cap_next)
  );

  assign nvec_in    = (num_vec > VCW'(MAX_VEC)) ? VCW'(MAX_VEC) : num_vec;
  assign nxt_vidx   = vidx_q + 1'b1;
  assign more       = (nxt_vidx < nvec_q);
  assign start_ok   = start && (state_q == ST_IDLE || state_q == ST_DONE);
  assign flush_err  = (state_q == ST_FLUSH) && chk_en && (scan_out != exp_bit);
  assign flush_end  = (state_q == ST_FLUSH) && (cnt_q == CW'(2 * N - 1));
  assign last_shift = (state_q == ST_SHIFT) && (cnt_q == CW'(N - 1));
  assign ns_err     = last_shift && have_prev_q && (cap_next != prev_ns_q);
  assign po_err     = (state_q == ST_CAPT) && (po != cur_po_q);
  assign su_shift   = (state_q == ST_FLUSH) || (state_q == ST_SHIFT);

  always_comb begin
    su_load = 1'b0;
    su_val  = '0;
    if (start_ok) begin
      su_load = 1'b1;
      su_val  = pat;
    end else if (flush_end && !flush_err && nvec_q != '0) begin
      su_load = 1'b1;
      su_val  = rd_data[PS_LO +: N];
    end else if (state_q == ST_CAPT && !po_err) begin
      su_load = 1'b1;
      su_val  = more ? rd_data[PS_LO +: N] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      vidx_q      <= '0;
      nvec_q      <= '0;
      rd_addr_q   <= '0;
      have_prev_q <= 1'b0;
      cur_pi_q    <= '0;
      cur_po_q    <= '0;
      cur_ns_q    <= '0;
      prev_ns_q   <= '0;
      pi_q        <= '0;
      tm_q        <= 1'b0;
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      pass_q      <= 1'b0;
      cfail_q     <= 1'b0;
      fidx_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            nvec_q    <= nvec_in;
            rd_addr_q <= '0;
            cnt_q     <= '0;
            tm_q      <= 1'b1;
            busy_q    <= 1'b1;
            done_q    <= 1'b0;
            pass_q    <= 1'b0;
            cfail_q   <= 1'b0;
            fidx_q    <= '0;
            state_q   <= ST_FLUSH;
          end
        end
        ST_FLUSH: begin
          cnt_q <= cnt_q + 1'b1;
          if (flush_err) begin
            cfail_q <= 1'b1;
            tm_q    <= 1'b0;
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_DONE;
          end else if (flush_end) begin
            if (nvec_q == '0) begin
              pass_q  <= 1'b1;
              tm_q    <= 1'b0;
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              cur_pi_q    <= rd_data[PI_LO +: PI_W];
              cur_po_q    <= rd_data[PO_LO +: PO_W];
              cur_ns_q    <= rd_data[NS_LO +: N];
              rd_addr_q   <= rd_addr_q + 1'b1;
              vidx_q      <= '0;
              have_prev_q <= 1'b0;
              cnt_q       <= '0;
              state_q     <= ST_SHIFT;
            end
          end
        end
        ST_SHIFT: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_shift) begin
            if (ns_err) begin
              fidx_q  <= VAW'(vidx_q - 1'b1);
              tm_q    <= 1'b0;
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
              state_q <= ST_DONE;
            end else if (vidx_q == nvec_q) begin
              pass_q  <= 1'b1;
              tm_q    <= 1'b0;
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              tm_q    <= 1'b0;
              pi_q    <= cur_pi_q;
              state_q <= ST_CAPT;
            end
          end
        end
        ST_CAPT: begin
          if (po_err) begin
            fidx_q  <= VAW'(vidx_q);
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            prev_ns_q   <= cur_ns_q;
            have_prev_q <= 1'b1;
            vidx_q      <= nxt_vidx;
            tm_q        <= 1'b1;
            cnt_q       <= '0;
            state_q     <= ST_SHIFT;
            if (more) begin
              cur_pi_q  <= rd_data[PI_LO +: PI_W];
              cur_po_q  <= rd_data[PO_LO +: PO_W];
              cur_ns_q  <= rd_data[NS_LO +: N];
              rd_addr_q <= rd_addr_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign test_mode  = tm_q;
  assign pi         = pi_q;
  assign busy       = busy_q;
  assign done       = done_q;
  assign pass       = pass_q;
  assign chain_fail = cfail_q;
  assign fail_idx   = fidx_q;

  // A functional clock is never followed by a second one inside a run.
  assert_single_capture_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !tm_q) |=> (tm_q || !busy_q));

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);

  assert_pass_needs_done_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(pass_q) |-> done_q);

  assert_chain_fail_no_pass_R3: assert property (@(posedge clk) disable iff (rst)
    cfail_q |-> !pass_q);

  assert_fail_idx_range_R7: assert property (@(posedge clk) disable iff (rst)
    (done_q && !pass_q && !cfail_q) |-> (VCW'(fidx_q) < nvec_q));

  assert_count_locked_R11: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(nvec_q));

endmodule

// File: tb/scan_test_seq_test.sv
module scan_test_seq_test;

  localparam int N = 8, PIW = 4, POW = 3, MV = 16;
  localparam int VAW = $clog2(MV), VCW = $clog2(MV + 1), EW = 2 * N + PIW + POW;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, tbl_we = 1'b0;
  logic [VCW-1:0] num_vec = '0;
  logic [VAW-1:0] tbl_addr = '0;
  logic [EW-1:0]  tbl_wdata = '0;
  logic tm, si, so, busy, done, pass, cfail;
  logic [PIW-1:0] piw;
  logic [POW-1:0] pow;
  logic [VAW-1:0] fidx;

  int errors = 0, checks = 0, cycles = 0;

  always #5 clk = ~clk;

  scan_test_seq #(.CHAIN_LEN(N), .PI_W(PIW), .PO_W(POW), .MAX_VEC(MV)) uut (
    .clk(clk), .rst(rst), .start(start), .num_vec(num_vec),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .test_mode(tm), .scan_in(si), .pi(piw), .scan_out(so), .po(pow),
    .busy(busy), .done(done), .pass(pass), .chain_fail(cfail), .fail_idx(fidx)
  );

  // Scanned circuit model with an optional stuck-at-0 on stage 3.
  logic [N-1:0] q, qe;
  logic stuck = 1'b0;

  function automatic logic [N-1:0] nsf(input logic [N-1:0] s, input logic [PIW-1:0] x);
    return {s[N-2:0], s[N-1]} ^ {x, x};
  endfunction

  function automatic logic [POW-1:0] pof(input logic [N-1:0] s, input logic [PIW-1:0] x);
    return {^s, s[N-1] & x[3], s[0] | x[1]};
  endfunction

  assign qe  = stuck ? (q & ~N'(8'h08)) : q;
  assign so  = qe[N-1];
  assign pow = pof(qe, piw);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (tm) q <= {qe[N-2:0], si};
    else         q <= nsf(qe, piw);
  end

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_entry(input int v, input logic [EW-1:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = VAW'(v); tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  function automatic logic [EW-1:0] entry(input int v, input logic [POW-1:0] po_x,
                                          input logic [N-1:0] ns_x);
    logic [N-1:0] ps;
    logic [PIW-1:0] x;
    ps = N'(v * 37 + 5);
    x  = PIW'(v * 5 + 3);
    return {ps, x, pof(ps, x) ^ po_x, nsf(ps, x) ^ ns_x};
  endfunction

  task automatic fill(input int nv);
    for (int v = 0; v < nv; v++) wr_entry(v, entry(v, '0, '0));
  endtask

  task automatic run(input int nv, input int poke, output int t1, output int t0);
    t1 = 0; t0 = 0;
    @(negedge clk);
    start = 1'b1; num_vec = VCW'(nv);
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 4000; c++) begin
      if (busy) begin
        if (tm) t1++; else t0++;
      end
      if (done) break;
      start = (c == poke);
      @(negedge clk);
    end
    start = 1'b0;
    chk("run reached done", int'(done), 1);
  endtask

  task automatic t_reset;
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 pass after reset", int'(pass), 0);
    chk("R1 chain_fail after reset", int'(cfail), 0);
    chk("R1 test_mode after reset", int'(tm), 0);
  endtask

  task automatic t_good;
    int t1, t0;
    fill(5);
    run(5, -1, t1, t0);
    chk("R2 R10 good run pass", int'(pass), 1);
    chk("R8 good run chain_fail", int'(cfail), 0);
    chk("R4 R6 R8 shift clocks", t1, 2 * N + 6 * N);
    chk("R5 R8 capture clocks", t0, 5);
  endtask

  task automatic t_zero;
    int t1, t0;
    run(0, -1, t1, t0);
    chk("R9 zero vectors pass", int'(pass), 1);
    chk("R9 zero vectors shift clocks", t1, 2 * N);
    chk("R9 zero vectors capture clocks", t0, 0);
  endtask

  task automatic t_po_fail;
    int t1, t0;
    fill(6);
    wr_entry(2, entry(2, 3'b001, '0));
    run(6, -1, t1, t0);
    chk("R5 output mismatch pass", int'(pass), 0);
    chk("R7 output mismatch index", int'(fidx), 2);
    chk("R7 output mismatch captures", t0, 3);
    chk("R7 output mismatch chain_fail", int'(cfail), 0);
  endtask

  task automatic t_ns_mid;
    int t1, t0;
    fill(6);
    wr_entry(3, entry(3, '0, N'(8'h40)));
    run(6, -1, t1, t0);
    chk("R6 interior next-state pass", int'(pass), 0);
    chk("R6 interior next-state index", int'(fidx), 3);
    chk("R7 interior next-state captures", t0, 4);
  endtask

  task automatic t_ns_last;
    int t1, t0;
    fill(6);
    wr_entry(5, entry(5, '0, N'(8'h01)));
    run(6, -1, t1, t0);
    chk("R6 last vector unload pass", int'(pass), 0);
    chk("R6 last vector unload index", int'(fidx), 5);
    chk("R6 last vector captures", t0, 6);
  endtask

  task automatic t_first_wins;
    int t1, t0;
    fill(6);
    wr_entry(1, entry(1, '0, N'(8'h80)));
    wr_entry(2, entry(2, 3'b100, '0));
    run(6, -1, t1, t0);
    chk("R7 earliest failure index", int'(fidx), 1);
    chk("R7 earliest failure captures", t0, 2);
  endtask

  task automatic t_chain;
    int t1, t0;
    fill(4);
    stuck = 1'b1;
    run(4, -1, t1, t0);
    stuck = 1'b0;
    chk("R3 chain_fail set", int'(cfail), 1);
    chk("R3 chain fault pass", int'(pass), 0);
    chk("R3 chain fault captures", t0, 0);
    chk("R3 chain fault shift clocks", t1, N + 3);
  endtask

  task automatic t_full;
    int t1, t0;
    fill(MV);
    run(MV, -1, t1, t0);
    chk("R8 R10 full table pass", int'(pass), 1);
    chk("R8 full table captures", t0, MV);
    chk("R8 full table shift clocks", t1, 2 * N + (MV + 1) * N);
  endtask

  task automatic t_busy_start;
    int t1, t0;
    fill(5);
    run(5, 30, t1, t0);
    chk("R11 restart ignored pass", int'(pass), 1);
    chk("R11 restart ignored shift clocks", t1, 2 * N + 6 * N);
    chk("R11 restart ignored captures", t0, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_good();
    t_zero();
    t_po_fail();
    t_ns_mid();
    t_ns_last();
    t_first_wins();
    t_chain();
    t_full();
    t_busy_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule